// File: doc/BRIEF.md
# Zero-Page Indirect Indexed Load Sequencer

This block steps an 8-bit processor through one addressing mode: a load into the accumulator through a two-byte pointer held in page zero, offset by the Y index register. It owns the program counter, the pointer and the effective-address arithmetic. Each clock cycle it drives one read address onto a 16-bit bus and samples the returned byte. The data bus is treated as combinational, so the byte at the driven address is captured on the next rising edge.

The sequence has a fixed timeline. First comes the opcode fetch, then the pointer operand, then the low and high base bytes from page zero. When adding Y to the low base byte carries into the high byte, the block spends one extra cycle on a read at the uncorrected address and discards the byte. The final read lands in the accumulator and updates the N and Z flags. In that same final cycle the interrupt inputs are sampled. The next opcode fetch follows directly, with no prefetch and no overlap between instructions. Any opcode other than the one for this mode is skipped in a single cycle.

Top module: `lda_izy_seq`

## Requirements
- R1: While reset is held, the address bus shows RESET_PC (default 0x0200), the accumulator is 0 and both flags are 0. The first cycle after release is an opcode fetch at RESET_PC.
- R2: In an opcode-fetch cycle, sync is 1, rd_en is 1 and the address equals the PC, and the PC then advances by one. An opcode byte other than 0xB1 makes the next cycle another opcode fetch at PC+1 and leaves the accumulator unchanged.
- R3: After 0xB1 is fetched at address P, the next cycle reads the pointer operand at P+1.
- R4: The two cycles after the operand read address 0x00pp and then 0x00qq, where pp is the operand and qq = (pp+1) mod 256. A pointer of 0xFF therefore reads its high byte from 0x0000.
- R5: When lo+Y is below 256, dummy_rd stays 0, the instruction takes 5 cycles, and the fifth cycle reads {hi,lo}+Y.
- R6: When lo+Y is 256 or more, the fifth cycle raises dummy_rd and reads {hi,(lo+Y) mod 256}. A sixth cycle then reads {hi,lo}+Y.
- R7: After the final cycle, acc holds the byte read there, flag_n equals bit 7 of that byte and flag_z is 1 exactly when the byte is zero. Neither acc nor the flags change at any other time.
- R8: instr_done is 1 only in the final cycle, and the cycle after it is an opcode fetch at the start PC plus 2.
- R9: int_nmi equals nmi and int_irq equals irq AND NOT i_flag AND NOT nmi, both only during the final cycle. Outside that cycle both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 8 | Byte returned from the current read address |
| y_in | input | 8 | Y index register value |
| i_flag | input | 1 | Interrupt-disable flag |
| irq | input | 1 | Maskable interrupt request level |
| nmi | input | 1 | Non-maskable interrupt request |
| addr | output | 16 | Read address for the current cycle |
| rd_en | output | 1 | Read strobe, high in every cycle |
| sync | output | 1 | Marks an opcode-fetch cycle |
| dummy_rd | output | 1 | Marks the discarded page-fix read |
| instr_done | output | 1 | Marks the final cycle of the load |
| int_nmi | output | 1 | NMI sampled at instruction end |
| int_irq | output | 1 | Unmasked IRQ sampled at instruction end |
| acc | output | 8 | Accumulator |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench sweeps Y and the low base byte across the carry boundary. A design that compared with the wrong bound would add a dummy cycle to a same-page access, or read the final byte one page too low. Pointers of 0xFF catch a 16-bit pointer increment, which would fetch the high byte from 0x0100 instead of 0x0000. Interrupt inputs cycle through all eight combinations, which exposes a masked IRQ leaking through and IRQ not yielding to NMI. Interleaved foreign opcodes show whether the sequencer wrongly enters the load path.

// File: rtl/lda_izy_pkg.sv
package lda_izy_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // Cycle of the load sequence; order follows the bus timeline.
  typedef enum logic [2:0] {
    ST_OP  = 3'd0,  // opcode fetch
    ST_ZP  = 3'd1,  // pointer operand fetch
    ST_BLO = 3'd2,  // low base byte from page zero
    ST_BHI = 3'd3,  // high base byte, index addition
    ST_FIX = 3'd4,  // discarded read, high byte correction
    ST_FIN = 3'd5   // effective read into the accumulator
  } seq_st_t;

  // Index addition with carry out in the top bit.
  function automatic logic [DATA_W:0] idx_add(byte_t base_lo, byte_t idx);
    return {1'b0, base_lo} + {1'b0, idx};
  endfunction

  // Pointer step that stays inside page zero.
  function automatic byte_t zp_next(byte_t p);
    return p + byte_t'(1);
  endfunction

  function automatic addr_t join_addr(byte_t hi, byte_t lo);
    return {hi, lo};
  endfunction

  function automatic logic is_zero(byte_t v);
    return v == '0;
  endfunction
endpackage

// File: rtl/izy_ctrl.sv
module izy_ctrl
  import lda_izy_pkg::*;
#(
  parameter byte_t OPCODE = 8'hB1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  byte_t   data_in,
  input  logic    page_cross,
  output seq_st_t state,
  output logic    sync,
  output logic    fix_cyc,
  output logic    fin_cyc
);
  seq_st_t nxt;
  logic    op_match;

  assign op_match = (state == ST_OP) && (data_in == OPCODE);
  assign sync     = (state == ST_OP);
  assign fix_cyc  = (state == ST_FIX);
  assign fin_cyc  = (state == ST_FIN);

  always_comb begin
    nxt = ST_OP;
    case (state)
      ST_OP:   nxt = op_match ? ST_ZP : ST_OP;
      ST_ZP:   nxt = ST_BLO;
      ST_BLO:  nxt = ST_BHI;
      ST_BHI:  nxt = page_cross ? ST_FIX : ST_FIN;
      ST_FIX:  nxt = ST_FIN;
      ST_FIN:  nxt = ST_OP;
      default: nxt = ST_OP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_OP;
    else        state <= nxt;
  end

  // R8: the fetch of the next opcode follows the final read directly
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_cyc |=> sync);

  // R6: a carry sends the sequence through the discarded read
  assert_cross_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BHI && page_cross) |=> fix_cyc);

  // R5: without a carry the final read comes next
  assert_flat_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BHI && !page_cross) |=> fin_cyc);

  // R2: a foreign opcode leads to another fetch
  assert_foreign_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && data_in != OPCODE) |=> sync);
endmodule

// File: rtl/izy_addr_unit.sv
module izy_addr_unit
  import lda_izy_pkg::*;
#(
  parameter addr_t RESET_PC = 16'h0200
) (
  input  logic    clk,
  input  logic    rst_n,
  input  seq_st_t state,
  input  byte_t   data_in,
  input  byte_t   y_in,
  output addr_t   addr,
  output logic    page_cross
);
  localparam addr_t PAGE_STEP = addr_t'(1) << DATA_W;

  addr_t           pc;
  byte_t           zp_ptr;
  byte_t           base_lo;
  byte_t           eff_lo;
  byte_t           eff_hi;
  logic [DATA_W:0] sum;

  assign sum        = idx_add(base_lo, y_in);
  assign page_cross = (state == ST_BHI) && sum[DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= RESET_PC;
      zp_ptr  <= '0;
      base_lo <= '0;
      eff_lo  <= '0;
      eff_hi  <= '0;
    end else begin
      case (state)
        ST_OP:  pc <= pc + addr_t'(1);
        ST_ZP: begin
          pc     <= pc + addr_t'(1);
          zp_ptr <= data_in;
        end
        ST_BLO: begin
          base_lo <= data_in;
          zp_ptr  <= zp_next(zp_ptr);
        end
        ST_BHI: begin
          eff_lo <= sum[DATA_W-1:0];
          eff_hi <= data_in;
        end
        ST_FIX: eff_hi <= eff_hi + byte_t'(1);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_OP, ST_ZP:   addr = pc;
      ST_BLO, ST_BHI: addr = join_addr('0, zp_ptr);
      default:        addr = join_addr(eff_hi, eff_lo);
    endcase
  end

  // R2/R3: each of the first two cycles moves the bus one byte on
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OP && $past(state) == ST_OP && $past(rst_n)) |->
      addr == $past(addr) + addr_t'(1));

  // R4: high pointer byte comes from the adjacent page-zero location
  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BLO) |=> addr == join_addr('0, zp_next($past(addr[DATA_W-1:0]))));

  // R6: the final read sits one page above the discarded read
  assert_fix_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIX) |=> addr == $past(addr) + PAGE_STEP);

  // R5: without a carry the final read keeps the fetched high byte
  assert_same_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BHI && !page_cross) |=> addr[ADDR_W-1:DATA_W] == $past(data_in));
endmodule

// File: rtl/izy_load_unit.sv
module izy_load_unit
  import lda_izy_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fin_cyc,
  input  byte_t data_in,
  input  logic  nmi,
  input  logic  irq,
  input  logic  i_flag,
  output byte_t acc,
  output logic  flag_n,
  output logic  flag_z,
  output logic  int_nmi,
  output logic  int_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (fin_cyc) begin
      acc    <= data_in;
      flag_n <= data_in[DATA_W-1];
      flag_z <= is_zero(data_in);
    end
  end

  // Interrupts are looked at only as the instruction ends; NMI wins.
  assign int_nmi = fin_cyc && nmi;
  assign int_irq = fin_cyc && irq && !i_flag && !nmi;

  // R9: the disable flag masks IRQ
  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    i_flag |-> !int_irq);

  // R9: nothing is reported away from instruction end
  assert_int_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_cyc |-> !(int_nmi || int_irq));

  // R7: flags follow the loaded byte
  assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fin_cyc) |-> (flag_z == is_zero(acc)) && (flag_n == acc[DATA_W-1]));

  // R7: the accumulator moves only after a final read
  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fin_cyc) && $past(rst_n)) |-> $stable(acc));
endmodule

// File: rtl/lda_izy_seq.sv
module lda_izy_seq
  import lda_izy_pkg::*;
#(
  parameter addr_t RESET_PC = 16'h0200,
  parameter byte_t OPCODE   = 8'hB1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  data_in,
  input  logic [7:0]  y_in,
  input  logic        i_flag,
  input  logic        irq,
  input  logic        nmi,
  output logic [15:0] addr,
  output logic        rd_en,
  output logic        sync,
  output logic        dummy_rd,
  output logic        instr_done,
  output logic        int_nmi,
  output logic        int_irq,
  output logic [7:0]  acc,
  output logic        flag_n,
  output logic        flag_z
);
  seq_st_t state;
  logic    page_cross;
  logic    fix_cyc;
  logic    fin_cyc;

  izy_ctrl #(.OPCODE(OPCODE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_in    (data_in),
    .page_cross (page_cross),
    .state      (state),
    .sync       (sync),
    .fix_cyc    (fix_cyc),
    .fin_cyc    (fin_cyc)
  );

  izy_addr_unit #(.RESET_PC(RESET_PC)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .data_in    (data_in),
    .y_in       (y_in),
    .addr       (addr),
    .page_cross (page_cross)
  );

  izy_load_unit u_load (
    .clk     (clk),
    .rst_n   (rst_n),
    .fin_cyc (fin_cyc),
    .data_in (data_in),
    .nmi     (nmi),
    .irq     (irq),
    .i_flag  (i_flag),
    .acc     (acc),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .int_nmi (int_nmi),
    .int_irq (int_irq)
  );

  // Every cycle of this sequence is a read.
  assign rd_en      = 1'b1;
  assign dummy_rd   = fix_cyc;
  assign instr_done = fin_cyc;

  // R6: the discarded read is always followed by the final read
  assert_fix_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_rd |=> instr_done);
endmodule

// File: tb/lda_izy_seq_tb.sv
module lda_izy_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  data_in, y_in;
  logic        i_flag, irq, nmi;
  logic [15:0] addr;
  logic        rd_en, sync, dummy_rd, instr_done, int_nmi, int_irq;
  logic [7:0]  acc;
  logic        flag_n, flag_z;

  logic [7:0]  mem [0:65535];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  logic [15:0] epc;
  logic [7:0]  eacc;

  always #10 clk = ~clk;

  assign data_in = mem[addr];

  lda_izy_seq u_dut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .y_in(y_in),
    .i_flag(i_flag), .irq(irq), .nmi(nmi), .addr(addr), .rd_en(rd_en),
    .sync(sync), .dummy_rd(dummy_rd), .instr_done(instr_done),
    .int_nmi(int_nmi), .int_irq(int_irq), .acc(acc),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL R8 watchdog expired: actual %0d expected %0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Entered at a falling edge while the DUT is in its opcode-fetch cycle.
  task automatic run_lda(input logic [7:0] zp, input logic [7:0] lo,
                         input logic [7:0] hi, input logic [7:0] y,
                         input bit nv, input bit iv, input bit fv);
    logic [8:0]  sum;
    logic [15:0] eff;
    logic [7:0]  val;
    mem[epc]                 = 8'hB1;
    mem[epc + 16'd1]         = zp;
    mem[{8'h00, zp}]         = lo;
    mem[{8'h00, zp + 8'd1}]  = hi;
    y_in = y; nmi = nv; irq = iv; i_flag = fv;
    sum = {1'b0, lo} + {1'b0, y};
    eff = {hi, lo} + {8'h00, y};
    #1;
    chk(addr == epc, "R2", "fetch addr", addr, epc);
    chk(sync && rd_en && !instr_done, "R2", "fetch strobes", {sync, rd_en, instr_done}, 3'b110);
    @(negedge clk);
    chk(addr == epc + 16'd1, "R3", "operand addr", addr, epc + 16'd1);
    chk(!sync, "R3", "sync low", sync, 0);
    chk(!int_nmi && !int_irq, "R9", "no int mid-instr", {int_nmi, int_irq}, 0);
    @(negedge clk);
    chk(addr == {8'h00, zp}, "R4", "ptr lo addr", addr, {8'h00, zp});
    @(negedge clk);
    chk(addr == {8'h00, zp + 8'd1}, "R4", "ptr hi addr", addr, {8'h00, zp + 8'd1});
    @(negedge clk);
    if (sum[8]) begin
      chk(dummy_rd && !instr_done, "R6", "dummy cycle", {dummy_rd, instr_done}, 2'b10);
      chk(addr == {hi, sum[7:0]}, "R6", "dummy addr", addr, {hi, sum[7:0]});
      @(negedge clk);
    end
    chk(!dummy_rd, "R5", "no dummy on final", dummy_rd, 0);
    chk(instr_done, "R8", "done on final", instr_done, 1);
    chk(addr == eff, sum[8] ? "R6" : "R5", "final addr", addr, eff);
    chk(int_nmi == nv, "R9", "nmi sample", int_nmi, nv);
    chk(int_irq == (iv && !fv && !nv), "R9", "irq sample", int_irq, iv && !fv && !nv);
    val = mem[eff];
    @(negedge clk);
    chk(acc == val, "R7", "acc", acc, val);
    chk(flag_n == val[7], "R7", "flag_n", flag_n, val[7]);
    chk(flag_z == (val == 8'h00), "R7", "flag_z", flag_z, val == 8'h00);
    chk(sync && addr == epc + 16'd2, "R8", "next fetch", addr, epc + 16'd2);
    epc  = epc + 16'd2;
    eacc = val;
  endtask

  task automatic run_foreign(input logic [7:0] op);
    mem[epc] = op;
    #1;
    chk(addr == epc && sync, "R2", "foreign fetch", addr, epc);
    @(negedge clk);
    chk(sync && addr == epc + 16'd1, "R2", "refetch after foreign", addr, epc + 16'd1);
    chk(acc == eacc, "R2", "acc kept", acc, eacc);
    epc = epc + 16'd1;
  endtask

  initial begin
    logic [7:0] ys [7];
    logic [7:0] los [6];
    int         k;
    ys  = '{8'h00, 8'h01, 8'h0F, 8'h7F, 8'h80, 8'hF1, 8'hFF};
    los = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hF0, 8'hFF};
    for (int a = 0; a < 65536; a++) mem[a] = a[7:0] ^ a[15:8] ^ 8'h3C;
    rst_n = 1'b0; y_in = '0; nmi = 0; irq = 0; i_flag = 0;
    epc = 16'h0200; eacc = 8'h00;
    repeat (3) @(negedge clk);
    chk(addr == 16'h0200, "R1", "reset addr", addr, 16'h0200);
    chk(acc == 8'h00 && !flag_n && !flag_z, "R1", "reset acc/flags", {acc, flag_n, flag_z}, 0);
    rst_n = 1'b1;
    // Example with page cross: base 0x1080 + 0xF1 -> dummy 0x1071, final 0x1171
    mem[16'h1171] = 8'h00;
    run_lda(8'h42, 8'h80, 8'h10, 8'hF1, 0, 0, 0);
    mem[16'h2010] = 8'h80;
    run_lda(8'hFF, 8'h00, 8'h20, 8'h10, 0, 1, 0);  // pointer wrap
    run_foreign(8'hEA);
    k = 0;
    foreach (ys[i]) begin
      foreach (los[j]) begin
        run_lda(8'(k * 37 + 3), los[j], 8'(8'h30 + k[3:0]), ys[i],
                k[0], k[1], k[2]);
        if (k % 9 == 4) run_foreign(8'(k));
        k++;
      end
    end
    run_lda(8'h00, 8'hFF, 8'h7F, 8'h01, 1, 1, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule